// File: doc/BRIEF.md
# External Interrupt Request Controller

This block takes one active-low interrupt pin from outside the chip and turns it into a single interrupt request for the processor. The pin first passes through a chain of synchronizer flops. Falling edges are found on the synchronized signal. An 8-bit control byte on a small synchronous register bus sets how the pin is treated. It selects one of two recognition styles: the pin held low, or a falling edge only. It also connects the pin to the request logic or cuts it off.

In edge style, a detected falling edge is held until the processor services the interrupt, which it signals with a one-cycle acknowledge. Reset also clears the held edge. A mode input sets the access rules. In special mode both control bits can be changed at any time. In normal or emulation mode the edge-style bit takes only the first write after reset. A reserved location next to the control byte reads as zero and ignores writes.

Top module: `irq_pin_ctrl`

## Requirements
- R1: The control byte is at bus offset 0x1E. Bit 7 is edge_style (1 = falling edge, 0 = low level). Bit 6 is pin_enable. Bits 5..0 always read 0, whatever value was written.
- R2: After reset the control byte reads 0x40 (level style, pin enabled) and irq_req is 0.
- R3: While pin_enable is 0, irq_req stays 0 for any activity on the pin.
- R4: In level style with the pin enabled, irq_req rises two clocks after the pin is driven low. It falls two clocks after the pin returns high.
- R5: In edge style with the pin enabled, a falling edge raises irq_req three clocks after the pin falls. irq_req stays high after the pin returns high.
- R6: With special_mode = 0, edge_style accepts only the first write to 0x1E after reset, even if that write leaves its value unchanged. pin_enable takes every write.
- R7: With special_mode = 1, both edge_style and pin_enable take every write to 0x1E.
- R8: Writing pin_enable = 0 drops a held edge. A falling edge that occurs while the pin is disabled is never held, so enabling the pin again does not raise irq_req.
- R9: Offset 0x0F always reads 0x00. A write to 0x0F changes neither that location nor the control byte.
- R10: An acknowledge pulse clears the held edge on the next clock. A later falling edge raises irq_req again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special access rules, 0 = normal/emulation |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| irq_ack | input | 1 | One-cycle pulse when the interrupt is serviced |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is the write-once lock on edge_style in normal mode. Seeing it needs a reset, then a first write, then a second write that tries a different value. The bench sweeps every pair of two-bit control values across both settings of special_mode, resetting before each pair. It also reaches a held edge that is then cut off by a pin_enable write, and an edge that arrives while the pin is disabled. Both cases read back irq_req after the pin is enabled again.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 5'h1E;
  localparam logic [ADDR_W-1:0] RSVD_OFS = 5'h0F;
  localparam int EDGE_BIT = 7;
  localparam int EN_BIT   = 6;

  typedef struct packed {
    logic edge_style;
    logic pin_enable;
  } irq_cfg_t;

  localparam irq_cfg_t CFG_RESET = '{edge_style: 1'b0, pin_enable: 1'b1};

  // Request equation: edge style uses the held edge, level style the synced low.
  function automatic logic irq_request(input irq_cfg_t cfg, input logic held,
                                       input logic pin_low);
    return cfg.pin_enable & (cfg.edge_style ? held : pin_low);
  endfunction

  function automatic logic [DATA_W-1:0] cfg_image(input irq_cfg_t cfg);
    logic [DATA_W-1:0] img;
    img = '0;
    img[EDGE_BIT] = cfg.edge_style;
    img[EN_BIT]   = cfg.pin_enable;
    return img;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync,
  output logic pin_prev
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= pin_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];

  assign pin_sync = chain_q[STAGES-1];
  assign pin_prev = prev_q;

  AST_SYNC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_prev == $past(pin_sync))); // R4
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output irq_cfg_t          cfg
);
  irq_cfg_t cfg_q;
  logic     edge_locked_q;
  logic     wr_ctrl;
  logic     edge_wr_ok;

  assign wr_ctrl    = bus_sel & bus_wr & (bus_addr == CTRL_OFS);
  assign edge_wr_ok = special_mode | ~edge_locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q         <= CFG_RESET;
      edge_locked_q <= 1'b0;
    end else if (wr_ctrl) begin
      cfg_q.pin_enable <= bus_wdata[EN_BIT];
      if (edge_wr_ok) cfg_q.edge_style <= bus_wdata[EDGE_BIT];
      if (!special_mode) edge_locked_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_addr == CTRL_OFS) bus_rdata = cfg_image(cfg_q);
  end

  assign cfg = cfg_q;

  AST_EDGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !special_mode && edge_locked_q) |=> $stable(cfg_q.edge_style)); // R6
  AST_EN_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (cfg_q.pin_enable == $past(bus_wdata[EN_BIT]))); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == RSVD_OFS) |-> (bus_rdata == '0)); // R9
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[5:0] == 6'd0); // R1
endmodule

// File: rtl/irq_edge_hold.sv
module irq_edge_hold
  import irq_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_cfg_t cfg,
  input  logic     pin_sync,
  input  logic     pin_prev,
  input  logic     ack,
  output logic     fall_evt,
  output logic     held_q,
  output logic     req
);
  logic set_hold;

  assign fall_evt = pin_prev & ~pin_sync;
  assign set_hold = fall_evt & cfg.edge_style & cfg.pin_enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              held_q <= 1'b0;
    else if (!cfg.pin_enable) held_q <= 1'b0;
    else if (set_hold)       held_q <= 1'b1;
    else if (ack)            held_q <= 1'b0;
  end

  assign req = irq_request(cfg, held_q, ~pin_sync);

  AST_HOLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.pin_enable |=> !held_q); // R8
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !ack && cfg.pin_enable) |=> held_q); // R5
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> cfg.pin_enable); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !fall_evt) |=> !held_q); // R10
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_pin_n,
  input  logic              irq_ack,
  output logic              irq_req
);
  irq_cfg_t cfg;
  logic     pin_sync, pin_prev, fall_evt, held_q;

  irq_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg(cfg)
  );

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(irq_pin_n),
    .pin_sync(pin_sync), .pin_prev(pin_prev)
  );

  irq_edge_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .pin_sync(pin_sync),
    .pin_prev(pin_prev), .ack(irq_ack), .fall_evt(fall_evt),
    .held_q(held_q), .req(irq_req)
  );

  AST_EDGE_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.edge_style && held_q && cfg.pin_enable) |-> irq_req); // R5
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt); // R5
endmodule

// File: tb/test_irq_pin_ctrl.sv
module test_irq_pin_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_pin_n = 1'b1, irq_ack = 1'b0;
  logic       irq_req;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pin_ctrl i_irq_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pin_n(irq_pin_n), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_pin_n = 1'b1; irq_ack = 1'b0; bus_sel = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [7:0] image(input logic es, input logic en);
    return {es, en, 6'd0};
  endfunction

  initial begin
    logic [7:0] rv;
    logic es_e, en_e, exp_req;
    // Write-once / anytime sweep: R1 R6 R7
    for (int sm = 0; sm < 2; sm++)
      for (int v1 = 0; v1 < 4; v1++)
        for (int v2 = 0; v2 < 4; v2++) begin
          special_mode = sm[0];
          do_reset();
          rd(5'h1E, rv); check("R2 reset image", rv, 8'h40);
          check("R2 reset req", {7'd0, irq_req}, 8'h00);
          wr(5'h1E, {v1[1], v1[0], 6'h3F});
          rd(5'h1E, rv); check("R1 first write", rv, image(v1[1], v1[0]));
          wr(5'h1E, {v2[1], v2[0], 6'h2A});
          es_e = sm[0] ? v2[1] : v1[1];
          en_e = v2[0];
          rd(5'h1E, rv);
          check(sm[0] ? "R7 special rewrite" : "R6 locked edge bit", rv, image(es_e, en_e));
        end

    // Request behaviour per configuration: R3 R4 R5 R10
    special_mode = 1'b1;
    for (int c = 0; c < 4; c++) begin
      es_e = c[1]; en_e = c[0];
      do_reset();
      wr(5'h1E, image(es_e, en_e));
      irq_pin_n = 1'b0;
      step(1); check("R4 no req after one clock", {7'd0, irq_req}, 8'h00);
      step(1); exp_req = en_e & ~es_e;
      check(en_e ? "R4 level latency" : "R3 disabled", {7'd0, irq_req}, {7'd0, exp_req});
      step(1); exp_req = en_e;
      check(en_e ? "R5 edge latency" : "R3 disabled", {7'd0, irq_req}, {7'd0, exp_req});
      irq_pin_n = 1'b1;
      step(1); check("R4 level still low in sync", {7'd0, irq_req}, {7'd0, en_e});
      step(1); exp_req = en_e & es_e;
      check(es_e ? "R5 edge held" : "R4 level release", {7'd0, irq_req}, {7'd0, exp_req});
      step(3); check("R5 hold persists", {7'd0, irq_req}, {7'd0, exp_req});
      irq_ack = 1'b1; step(1); irq_ack = 1'b0;
      check("R10 ack clears", {7'd0, irq_req}, 8'h00);
      irq_pin_n = 1'b0; step(3);
      check("R10 new edge after ack", {7'd0, irq_req}, {7'd0, en_e});
      irq_pin_n = 1'b1; step(3);
    end

    // R8: disabling drops a held edge; an edge while disabled is lost
    do_reset();
    wr(5'h1E, 8'hC0);
    irq_pin_n = 1'b0; step(3); irq_pin_n = 1'b1; step(2);
    check("R8 held before disable", {7'd0, irq_req}, 8'h01);
    wr(5'h1E, 8'h80);
    check("R8 disabled req", {7'd0, irq_req}, 8'h00);
    wr(5'h1E, 8'hC0); step(1);
    check("R8 held dropped", {7'd0, irq_req}, 8'h00);
    wr(5'h1E, 8'h80);
    irq_pin_n = 1'b0; step(4);
    wr(5'h1E, 8'hC0); step(2);
    check("R8 edge while disabled lost", {7'd0, irq_req}, 8'h00);
    irq_pin_n = 1'b1; step(3);

    // R9: reserved location
    do_reset();
    wr(5'h0F, 8'hFF);
    rd(5'h0F, rv); check("R9 reserved reads zero", rv, 8'h00);
    rd(5'h1E, rv); check("R9 control untouched", rv, 8'h40);

    // R6 with an unchanged value still locks
    special_mode = 1'b0;
    do_reset();
    wr(5'h1E, 8'h40); wr(5'h1E, 8'hC0);
    rd(5'h1E, rv); check("R6 same-value write locks", rv, 8'h40);
    wr(5'h1E, 8'h00);
    rd(5'h1E, rv); check("R6 enable still writable", rv, 8'h00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule